// File: doc/BRIEF.md
# Collision-Avoidance Transmit Scheduler

This block decides the moment at which a packet that is waiting to go out may start on air. A requester raises `tx_req` and holds it. The scheduler then applies one of four access policies, chosen by two mode bits. When the policy is satisfied it pulses `grant` for one cycle to the framer and drives the transmitter enable. It keeps that enable active until the request is withdrawn. The two radio enables are active low and are never active at the same time.

There are four policies. Mode `00` sends at once. Mode `01` waits a time slot whose length comes from the slot index and the packet geometry. Mode `10` powers the receiver, waits for it to settle, and holds off for as long as the channel is busy. Mode `11` does the same, but a busy channel makes it switch the receiver off for a random number of milliseconds before it tries again. All delays are counted in `tick_100us` or `tick_ms` pulses that the surrounding logic supplies.

The states are S_IDLE, S_SLOT, S_SETTLE, S_LISTEN, S_BACKOFF, S_TURN, S_GRANT and S_AIR. Their transitions are as follows:
- S_IDLE moves on a request: mode 00 goes to S_GRANT, mode 01 to S_SLOT, and modes 1x to S_SETTLE.
- S_SLOT moves to S_GRANT when the slot count is reached.
- S_SETTLE moves to S_LISTEN when the settle count is reached.
- S_LISTEN moves to S_TURN if the channel is clear. If it is busy, it moves to S_BACKOFF in mode 11 and stays put in mode 10.
- S_BACKOFF moves to S_SETTLE when the back-off count is reached.
- S_TURN moves to S_GRANT when the changeover count is reached.
- S_GRANT moves to S_AIR while the request is held.
- S_AIR moves to S_IDLE when the request drops.
- Any waiting state returns to S_IDLE when the request drops.

Top module: `air_access_sched`

## Requirements
- R1: With mode bits {mode_listen,mode_delay}=00, `grant` is high in the cycle that follows the first clock edge at which the request is seen. The receiver enable stays inactive throughout.
- R2: In mode 01 the grant follows after exactly ceil(slot × (preamble + 6×bytes + 6×turn + 10) / 2) 100 µs ticks. This is the slot delay slot × (preamble×0.05 + bytes×0.30 + 3×turn×0.1 + 0.5) ms, rounded up to whole 100 µs ticks. A slot of 0 grants at once. The receiver is never enabled in this mode.
- R3: In modes 10 and 11, `rx_en_n` is low for `settle_delay` 100 µs ticks before the channel is first sampled. If the channel is busy in mode 10, the block keeps listening and gives no grant. Once the channel is clear, the receiver turns off and `turn_delay` 100 µs ticks pass before the grant.
- R4: In mode 11, a busy channel at the sample switches the receiver off. The block then waits a back-off of B ms ticks, with 0 ≤ B ≤ 2^backoff_exp − 1, and repeats the settle and the sample.
- R5: B is the low backoff_exp bits of a 16-bit LFSR that advances every clock. It is 0 when backoff_exp=0, and successive back-offs vary.
- R6: `rx_en_n` and `tx_en_n` are never low together.
- R7: `grant` lasts exactly one cycle and coincides with the first cycle of `tx_en_n` low. `tx_en_n` stays low while `tx_req` is held, and goes high the cycle after the request drops.
- R8: If `tx_req` drops before a grant, both enables are inactive from the next cycle and no grant is given. A later request starts the full sequence afresh.
- R9: After reset, `rx_en_n`=1, `tx_en_n`=1 and `grant`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Packet waiting; held high until the transmission ends |
| mode_listen | input | 1 | 1 = check the channel before sending |
| mode_delay | input | 1 | 1 = slot delay (no check) or random back-off (with check) |
| chan_busy | input | 1 | Receiver reports preamble or data on the channel |
| tick_ms | input | 1 | One-cycle pulse every 1 ms |
| tick_100us | input | 1 | One-cycle pulse every 100 µs |
| slot_index | input | 8 | Slot number, 0 to 255 |
| backoff_exp | input | 3 | Back-off range exponent N, 0 to 7 |
| preamble_len | input | 8 | Preamble cycles per packet |
| pkt_bytes | input | 5 | Bytes per packet |
| turn_delay | input | 8 | Transmit/receive changeover delay, in 100 µs units |
| settle_delay | input | 8 | Receiver power-up settling delay, in 100 µs units |
| rx_en_n | output | 1 | Receiver enable, active low |
| tx_en_n | output | 1 | Transmitter enable, active low |
| grant | output | 1 | One-cycle start pulse to the framer |

## Verification
A wrong state or wrong count shows up as a wrong number of ticks between the request and the grant. Such an error is therefore visible within one access attempt, at the latest when the grant arrives early or late. A wrong decode of the mode bits appears straight away on `rx_en_n`, one cycle after the request. A fault in the back-off path shows as an off-time outside the 0 to 2^N − 1 range, or as identical off-times across many retries. The bench counts ticks by aligning requests and channel changes to the tick phase, so that each count can be compared exactly.

// File: rtl/txs_pkg.sv
package txs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SLOT,
        S_SETTLE,
        S_LISTEN,
        S_BACKOFF,
        S_TURN,
        S_GRANT,
        S_AIR
    } txs_state_e;
endpackage

// File: rtl/txs_slot_len.sv
// Slot delay in 100 us ticks: ceil(slot * len / 2), where len is in 50 us units.
module txs_slot_len #(
    parameter int SLOT_W  = 8,
    parameter int PRE_W   = 8,
    parameter int BYTES_W = 5,
    parameter int DLY_W   = 8,
    parameter int LEN_W   = ((PRE_W > DLY_W) ? PRE_W : DLY_W) + 4,
    parameter int OUT_W   = SLOT_W + LEN_W
) (
    input  logic [SLOT_W-1:0]  slot,
    input  logic [PRE_W-1:0]   pre,
    input  logic [BYTES_W-1:0] bytes,
    input  logic [DLY_W-1:0]   turn,
    output logic [OUT_W-1:0]   ticks
);
    logic [LEN_W-1:0] len;
    logic [OUT_W-1:0] prod;

    always_comb begin
        len   = LEN_W'(pre) + LEN_W'(bytes) * LEN_W'(6)
              + LEN_W'(turn) * LEN_W'(6) + LEN_W'(10);
        prod  = OUT_W'(slot) * OUT_W'(len);
        ticks = (prod + OUT_W'(1)) >> 1;
    end
endmodule

// File: rtl/txs_lfsr.sv
module txs_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value <= W'(SEED);
        else
            value <= {1'b0, value[W-1:1]} ^ (value[0] ? W'(TAPS) : '0);
    end
endmodule

// File: rtl/txs_wait_timer.sv
// Counts tick pulses from a clear up to a target; done holds while count == target.
module txs_wait_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (tick && (cnt != target))
            cnt <= cnt + W'(1);
    end

    assign done = (cnt == target);
endmodule

// File: rtl/air_access_sched.sv
module air_access_sched #(
    parameter int SLOT_W  = 8,
    parameter int PRE_W   = 8,
    parameter int BYTES_W = 5,
    parameter int DLY_W   = 8,
    parameter int EXP_W   = 3,
    parameter int LFSR_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_req,
    input  logic               mode_listen,
    input  logic               mode_delay,
    input  logic               chan_busy,
    input  logic               tick_ms,
    input  logic               tick_100us,
    input  logic [SLOT_W-1:0]  slot_index,
    input  logic [EXP_W-1:0]   backoff_exp,
    input  logic [PRE_W-1:0]   preamble_len,
    input  logic [BYTES_W-1:0] pkt_bytes,
    input  logic [DLY_W-1:0]   turn_delay,
    input  logic [DLY_W-1:0]   settle_delay,
    output logic               rx_en_n,
    output logic               tx_en_n,
    output logic               grant
);
    import txs_pkg::*;

    localparam int LEN_W = ((PRE_W > DLY_W) ? PRE_W : DLY_W) + 4;
    localparam int CNT_W = SLOT_W + LEN_W;
    localparam int BO_W  = (1 << EXP_W) - 1;

    txs_state_e state_q, state_d;

    logic [CNT_W-1:0]  slot_ticks;
    logic [CNT_W-1:0]  wait_target;
    logic              wait_tick;
    logic              wait_done;
    logic              wait_clr;
    logic [LFSR_W-1:0] rnd;
    logic [BO_W-1:0]   bo_mask;
    logic [BO_W-1:0]   bo_q;

    txs_slot_len #(
        .SLOT_W (SLOT_W),
        .PRE_W  (PRE_W),
        .BYTES_W(BYTES_W),
        .DLY_W  (DLY_W),
        .LEN_W  (LEN_W),
        .OUT_W  (CNT_W)
    ) u_slot (
        .slot (slot_index),
        .pre  (preamble_len),
        .bytes(pkt_bytes),
        .turn (turn_delay),
        .ticks(slot_ticks)
    );

    txs_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .value(rnd)
    );

    txs_wait_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wait_clr),
        .tick  (wait_tick),
        .target(wait_target),
        .done  (wait_done)
    );

    // Timer source and limit follow the state being timed.
    always_comb begin
        wait_tick   = tick_100us;
        wait_target = '0;
        unique case (state_q)
            S_SLOT:    wait_target = slot_ticks;
            S_SETTLE:  wait_target = CNT_W'(settle_delay);
            S_TURN:    wait_target = CNT_W'(turn_delay);
            S_BACKOFF: begin
                wait_target = CNT_W'(bo_q);
                wait_tick   = tick_ms;
            end
            S_IDLE, S_LISTEN, S_GRANT, S_AIR: wait_target = '0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (tx_req) begin
                    if (mode_listen)     state_d = S_SETTLE;
                    else if (mode_delay) state_d = S_SLOT;
                    else                 state_d = S_GRANT;
                end
            end
            S_SLOT:    if (!tx_req) state_d = S_IDLE;
                       else if (wait_done) state_d = S_GRANT;
            S_SETTLE:  if (!tx_req) state_d = S_IDLE;
                       else if (wait_done) state_d = S_LISTEN;
            S_LISTEN: begin
                if (!tx_req)         state_d = S_IDLE;
                else if (!chan_busy) state_d = S_TURN;
                else if (mode_delay) state_d = S_BACKOFF;
            end
            S_BACKOFF: if (!tx_req) state_d = S_IDLE;
                       else if (wait_done) state_d = S_SETTLE;
            S_TURN:    if (!tx_req) state_d = S_IDLE;
                       else if (wait_done) state_d = S_GRANT;
            S_GRANT:   state_d = tx_req ? S_AIR : S_IDLE;
            S_AIR:     if (!tx_req) state_d = S_IDLE;
        endcase
    end

    assign wait_clr = (state_d != state_q);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Back-off length is captured when the busy channel is seen.
    always_comb bo_mask = {BO_W{1'b1}} >> (BO_W - int'(backoff_exp));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bo_q <= '0;
        else if (state_q == S_LISTEN && state_d == S_BACKOFF)
            bo_q <= rnd[BO_W-1:0] & bo_mask;
    end

    // Output decode.
    always_comb begin
        rx_en_n = 1'b1;
        tx_en_n = 1'b1;
        grant   = 1'b0;
        unique case (state_q)
            S_SETTLE, S_LISTEN: rx_en_n = 1'b0;
            S_GRANT: begin
                tx_en_n = 1'b0;
                grant   = 1'b1;
            end
            S_AIR:   tx_en_n = 1'b0;
            S_IDLE, S_SLOT, S_BACKOFF, S_TURN: ;
        endcase
    end
endmodule

// File: rtl/air_access_sched_chk.sv
module air_access_sched_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_req,
    input logic               mode_listen,
    input logic               mode_delay,
    input logic               chan_busy,
    input txs_pkg::txs_state_e state,
    input logic               rx_en_n,
    input logic               tx_en_n,
    input logic               grant
);
    import txs_pkg::*;

    a_r6_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rx_en_n && !tx_en_n));

    a_r7_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

    a_r7_grant_with_tx: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !tx_en_n);

    a_r7_tx_starts_at_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_n) |-> grant);

    a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> (rx_en_n && tx_en_n && !grant));

    a_r1_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && tx_req && !mode_listen && !mode_delay) |=> grant);

    a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LISTEN && tx_req && chan_busy && !mode_delay) |=> (!rx_en_n && tx_en_n));

    a_r4_backoff_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LISTEN && tx_req && chan_busy && mode_delay) |=> (state == S_BACKOFF && rx_en_n));
endmodule

bind air_access_sched air_access_sched_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .mode_listen(mode_listen),
    .mode_delay (mode_delay),
    .chan_busy  (chan_busy),
    .state      (state_q),
    .rx_en_n    (rx_en_n),
    .tx_en_n    (tx_en_n),
    .grant      (grant)
);

// File: tb/tb_air_access_sched.sv
module tb_air_access_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_req = 1'b0;
    logic       mode_listen = 1'b0;
    logic       mode_delay = 1'b0;
    logic       chan_busy = 1'b0;
    logic [7:0] slot_index = '0;
    logic [2:0] backoff_exp = '0;
    logic [7:0] preamble_len = 8'd1;
    logic [4:0] pkt_bytes = 5'd1;
    logic [7:0] turn_delay = 8'd1;
    logic [7:0] settle_delay = 8'd1;
    logic       rx_en_n, tx_en_n, grant;
    logic       tick_100us, tick_ms;
    logic [2:0] ph = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_total = 0;

    always #5 clk = ~clk;

    // Ticks: one cycle high out of every six, changed on the falling edge.
    always @(negedge clk) ph <= (ph == 3'd5) ? 3'd0 : ph + 3'd1;
    assign tick_100us = (ph == 3'd0);
    assign tick_ms    = (ph == 3'd0);

    air_access_sched dut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req),
        .mode_listen(mode_listen), .mode_delay(mode_delay),
        .chan_busy(chan_busy), .tick_ms(tick_ms), .tick_100us(tick_100us),
        .slot_index(slot_index), .backoff_exp(backoff_exp),
        .preamble_len(preamble_len), .pkt_bytes(pkt_bytes),
        .turn_delay(turn_delay), .settle_delay(settle_delay),
        .rx_en_n(rx_en_n), .tx_en_n(tx_en_n), .grant(grant)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (cyc_total > 190000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc_total);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic int exp_slot(int s, int p, int b, int t);
        return (s * (p + 6 * b + 6 * t + 10) + 1) / 2;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Step to just after a tick has ended, at a falling edge.
    task automatic align();
        do begin
            @(negedge clk);
            #1;
        end while (ph != 3'd1);
    endtask

    int  r_ticks, r_cyc, r_bo;
    bit  r_got, r_rx;

    // Raise the request and count ticks until the grant is seen.
    // If release_on_off is set, the channel goes clear once the receiver turns off.
    task automatic run_req(input bit release_on_off);
        bit rx_low_seen;
        rx_low_seen = 0;
        r_ticks = 0; r_cyc = 0; r_got = 0; r_rx = 0; r_bo = 0;
        align();
        tx_req = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            if (tick_100us) r_ticks++;
            r_cyc++;
            #1;
            if (!rx_en_n) begin rx_low_seen = 1; r_rx = 1; end
            if (release_on_off && rx_low_seen && rx_en_n) chan_busy = 1'b0;
            if (grant) begin r_got = 1; break; end
        end
    endtask

    // After a grant: single-cycle pulse, held enable, release.
    task automatic finish_air();
        @(posedge clk); #1;
        check(!grant && !tx_en_n, "R7 grant single, tx held", {grant, tx_en_n}, 0);
        @(posedge clk); #1;
        check(!tx_en_n, "R7 tx held while requested", tx_en_n, 0);
        @(negedge clk);
        tx_req = 1'b0;
        @(posedge clk); #1;
        check(tx_en_n && rx_en_n, "R7 release to idle", {tx_en_n, rx_en_n}, 3);
        repeat (3) @(posedge clk);
    endtask

    int bo_seen[8];

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        check(rx_en_n && tx_en_n && !grant, "R9 reset outputs", {rx_en_n, tx_en_n, grant}, 6);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 immediate mode
        mode_listen = 0; mode_delay = 0;
        run_req(0);
        check(r_got && r_cyc == 1, "R1 immediate grant cycles", r_cyc, 1);
        check(!r_rx, "R1 receiver unused", r_rx, 0);
        finish_air();

        // R2 slot 0 grants at once
        mode_listen = 0; mode_delay = 1; slot_index = 0;
        run_req(0);
        check(r_got && r_ticks == 0, "R2 slot zero ticks", r_ticks, 0);
        finish_air();

        // R2 rounding case: 3 * 23 = 69 half-ticks -> 35 ticks
        slot_index = 3; preamble_len = 1; pkt_bytes = 1; turn_delay = 1;
        run_req(0);
        check(r_got && r_ticks == 35, "R2 slot rounding", r_ticks, 35);
        check(!r_rx, "R2 receiver unused", r_rx, 0);
        finish_air();

        // R3 mode 10 with clear channel
        mode_listen = 1; mode_delay = 0; settle_delay = 4; turn_delay = 3; chan_busy = 0;
        run_req(0);
        check(r_got && r_ticks == 7, "R3 settle+turn ticks", r_ticks, 7);
        check(r_rx, "R3 receiver enabled", r_rx, 1);
        finish_air();

        // R3 mode 10 busy: hold, then clear
        chan_busy = 1; settle_delay = 2; turn_delay = 5;
        align();
        tx_req = 1'b1;
        begin
            bit g = 0;
            for (int i = 0; i < 90; i++) begin
                @(posedge clk); #1;
                if (grant || !tx_en_n) g = 1;
            end
            check(!g, "R3 no grant while busy", g, 0);
            check(!rx_en_n, "R3 listening while busy", rx_en_n, 0);
        end
        align();
        chan_busy = 0;
        begin
            int t = 0;
            bit g = 0;
            for (int i = 0; i < 200; i++) begin
                @(posedge clk);
                if (tick_100us) t++;
                #1;
                if (grant) begin g = 1; break; end
            end
            check(g && t == 5, "R3 turn ticks after clear", t, 5);
        end
        finish_air();

        // R8 drop request while settling, then a fresh request
        chan_busy = 1; settle_delay = 5; turn_delay = 2;
        align();
        tx_req = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        check(!rx_en_n, "R8 settling before drop", rx_en_n, 0);
        @(negedge clk);
        tx_req = 1'b0;
        @(posedge clk); #1;
        check(rx_en_n && tx_en_n && !grant, "R8 idle after drop", {rx_en_n, tx_en_n, grant}, 6);
        repeat (4) @(posedge clk);
        chan_busy = 0;
        run_req(0);
        check(r_got && r_ticks == 7, "R8 fresh sequence", r_ticks, 7);
        finish_air();

        // R5 backoff_exp = 0 gives zero back-off
        mode_listen = 1; mode_delay = 1; backoff_exp = 0; settle_delay = 3; turn_delay = 2;
        chan_busy = 1;
        run_req(1);
        check(r_got && r_ticks == 8, "R5 zero back-off", r_ticks, 8);
        finish_air();

        // R4/R5 random back-off in range and varying
        backoff_exp = 3; settle_delay = 1; turn_delay = 1;
        for (int k = 0; k < 8; k++) begin
            chan_busy = 1;
            run_req(1);
            bo_seen[k] = r_ticks - 3;
            check(r_got && bo_seen[k] >= 0 && bo_seen[k] <= 7, "R4 back-off range", bo_seen[k], 7);
            finish_air();
        end
        begin
            bit diff = 0;
            for (int k = 1; k < 8; k++) if (bo_seen[k] != bo_seen[0]) diff = 1;
            check(diff, "R5 back-offs vary", diff, 1);
        end

        // Random mix
        for (int k = 0; k < 24; k++) begin
            int m = $urandom_range(0, 3);
            mode_listen  = m[1];
            mode_delay   = m[0];
            slot_index   = 8'($urandom_range(0, 5));
            preamble_len = 8'($urandom_range(1, 40));
            pkt_bytes    = 5'($urandom_range(1, 27));
            turn_delay   = 8'($urandom_range(1, 4));
            settle_delay = 8'($urandom_range(1, 6));
            backoff_exp  = 3'($urandom_range(0, 7));
            chan_busy    = (m == 3) ? 1'($urandom_range(0, 1)) : 1'b0;
            run_req(chan_busy);
            if (m == 0)
                check(r_got && r_cyc == 1, "R1 random immediate", r_cyc, 1);
            else if (m == 1)
                check(r_got && r_ticks == exp_slot(slot_index, preamble_len, pkt_bytes, turn_delay),
                      "R2 random slot", r_ticks,
                      exp_slot(slot_index, preamble_len, pkt_bytes, turn_delay));
            else if (m == 3 && r_ticks != settle_delay + turn_delay) begin
                int bo = r_ticks - 2 * settle_delay - turn_delay;
                check(r_got && bo >= 0 && bo < (1 << backoff_exp), "R4 random back-off", bo,
                      (1 << backoff_exp) - 1);
            end else
                check(r_got && r_ticks == settle_delay + turn_delay, "R3 random listen", r_ticks,
                      settle_delay + turn_delay);
            finish_air();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule